// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block serialises data words onto a single output line, one bit per bit period. The bit period is marked by a one-cycle enable strobe from an external clock generator. A start event opens a frame. The frame can begin with an in-band synchronisation field of programmable length, taken from a dedicated pattern input. A programmable number of idle bit periods follows. After that the block sends a programmable number of words. Each word has a programmable length and is sent most-significant or least-significant bit first, as configured.

Words arrive on a valid/ready interface. A word is taken only at the instant a word slot opens. If no word is offered at that instant, the slot is filled with the idle level and an underrun pulse is raised. When no frame is in progress, the line carries a configurable idle level. The block snapshots all frame settings when it accepts a start event. Start events that arrive while a frame is running are dropped.

Top module: `framed_sync_tx`

## Requirements
- R1: During reset `tx_data`, `tx_busy`, `wr_ready`, `sync_seen` and `underrun` are all low. With no frame running, `tx_data` equals the value `cfg_idle_lvl` had one clock earlier.
- R2: A `start_evt` seen while `tx_busy` is low is accepted. `sync_seen` is then high for exactly the next cycle, and `tx_busy` rises in that same cycle.
- R3: If `cfg_sync_en` is 1 and L = {`cfg_sync_len_hi`,`cfg_sync_len_lo`} is nonzero, the first L bit periods of the frame carry bits 0..L-1 of `cfg_sync_data`. With MSB-first order the sequence is bit L-1 down to bit 0; otherwise it is bit 0 up to bit L-1. If L is 0 or the enable is 0, no sync bits are sent.
- R4: After the sync field, `cfg_delay` bit periods (0 to 255) carry the idle level.
- R5: Then `cfg_word_cnt`+1 words are sent, each of `cfg_word_len`+1 bits. With `cfg_msb_first`=1 the bits go from index `cfg_word_len` down to 0; with 0 they go from index 0 upward.
- R6: `wr_ready` is high only during a cycle in which `bit_en` opens a word slot. A word is consumed when `wr_valid` and `wr_ready` are both high.
- R7: If `wr_valid` is low when a slot opens, every bit of that slot is the idle level, `underrun` is high the next cycle, and no word is consumed.
- R8: A `start_evt` while `tx_busy` is high is ignored. It raises no `sync_seen` and does not alter the frame in progress.
- R9: One bit period after the last data bit, `tx_data` returns to the idle level and `tx_busy` falls.
- R10: While `tx_busy` is high, `tx_data` changes only after a cycle with `bit_en` high.
- R11: Order, lengths, counts, delay, sync pattern and in-frame idle level are captured when the start is accepted. Changing them during the frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-period strobe, one cycle per bit |
| start_evt | input | 1 | Start event pulse |
| cfg_idle_lvl | input | 1 | Line level when not sending |
| cfg_sync_en | input | 1 | Enable the in-band sync field |
| cfg_sync_len_hi | input | 1 | Upper bit of sync field length |
| cfg_sync_len_lo | input | SYNC_LO_W (4) | Lower bits of sync field length |
| cfg_sync_data | input | 2^(SYNC_LO_W+1)-1 (31) | Sync field pattern |
| cfg_delay | input | DLY_W (8) | Idle bit periods before the data |
| cfg_word_len | input | log2(WORD_W) (5) | Word length minus one |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_word_cnt | input | NWORD_W (8) | Words per frame minus one |
| wr_data | input | WORD_W (32) | Word to send |
| wr_valid | input | 1 | Word offered |
| wr_ready | output | 1 | Word taken this cycle |
| tx_data | output | 1 | Serial data line |
| tx_busy | output | 1 | Frame in progress |
| sync_seen | output | 1 | Start accepted (one-cycle pulse) |
| underrun | output | 1 | A slot opened with no word (one-cycle pulse) |

## Verification
The hardest situation to reach is a slot that opens with no word, while later slots of the same frame still complete normally. The stimulus withholds `wr_valid` through the first slot of a three-word frame and enables the feed partway through it. The comparison must then show an idle-filled slot followed by the queued words in order. Start pulses dropped in mid-frame, and configuration changes made just after acceptance, are applied while the frame is running. The cycle-accurate model must show that neither alters the frame.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_GAP,
        PH_DATA,
        PH_TAIL
    } phase_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
    import fstx_pkg::*;
#(
    parameter int LEN_W   = 5,
    parameter int SLEN_W  = 5,
    parameter int DLY_W   = 8,
    parameter int NWORD_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               start_evt,
    input  logic               cfg_sync_en,
    input  logic [SLEN_W-1:0]  cfg_sync_len,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic [LEN_W-1:0]   cfg_word_len,
    input  logic [NWORD_W-1:0] cfg_word_cnt,
    output phase_t             phase,
    output logic [CNT_W-1:0]   step,
    output logic [LEN_W-1:0]   wlen,
    output logic [SLEN_W-1:0]  slen,
    output logic               accept,
    output logic               slot_open
);

    phase_t             ph_q;
    logic [CNT_W-1:0]   step_q;
    logic [SLEN_W-1:0]  slen_q;
    logic [DLY_W-1:0]   dly_q;
    logic [LEN_W-1:0]   wlen_q;
    logic [NWORD_W-1:0] wcnt_q;
    logic [NWORD_W-1:0] widx_q;

    logic   sync_on;
    phase_t first_ph;
    phase_t after_sync;

    assign accept     = (ph_q == PH_IDLE) && start_evt;
    assign sync_on    = cfg_sync_en && (cfg_sync_len != '0);
    assign first_ph   = sync_on ? PH_SYNC : ((cfg_delay != '0) ? PH_GAP : PH_DATA);
    assign after_sync = (dly_q != '0) ? PH_GAP : PH_DATA;
    assign slot_open  = (ph_q == PH_DATA) && bit_en && (step_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            step_q <= '0;
            slen_q <= '0;
            dly_q  <= '0;
            wlen_q <= '0;
            wcnt_q <= '0;
            widx_q <= '0;
        end else if (accept) begin
            ph_q   <= first_ph;
            step_q <= '0;
            widx_q <= '0;
            slen_q <= cfg_sync_len;
            dly_q  <= cfg_delay;
            wlen_q <= cfg_word_len;
            wcnt_q <= cfg_word_cnt;
        end else if (bit_en) begin
            unique case (ph_q)
                PH_SYNC: begin
                    if (step_q == CNT_W'(slen_q) - CNT_W'(1)) begin
                        step_q <= '0;
                        ph_q   <= after_sync;
                    end else begin
                        step_q <= step_q + CNT_W'(1);
                    end
                end
                PH_GAP: begin
                    if (step_q == CNT_W'(dly_q) - CNT_W'(1)) begin
                        step_q <= '0;
                        ph_q   <= PH_DATA;
                    end else begin
                        step_q <= step_q + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    if (step_q == CNT_W'(wlen_q)) begin
                        step_q <= '0;
                        if (widx_q == wcnt_q) begin
                            ph_q <= PH_TAIL;
                        end else begin
                            widx_q <= widx_q + NWORD_W'(1);
                        end
                    end else begin
                        step_q <= step_q + CNT_W'(1);
                    end
                end
                PH_TAIL: ph_q <= PH_IDLE;
                default: ph_q <= ph_q;
            endcase
        end
    end

    assign phase = ph_q;
    assign step  = step_q;
    assign wlen  = wlen_q;
    assign slen  = slen_q;

endmodule

// File: rtl/fstx_dpath.sv
module fstx_dpath
    import fstx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SYNC_W = 31,
    parameter int LEN_W  = 5,
    parameter int SLEN_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              accept,
    input  logic              slot_open,
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  step,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [SLEN_W-1:0] slen,
    input  logic              cfg_msb_first,
    input  logic              cfg_idle_lvl,
    input  logic [SYNC_W-1:0] cfg_sync_data,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              tx_data,
    output logic              sync_seen,
    output logic              underrun
);

    logic              msb_q;
    logic              idle_q;
    logic [SYNC_W-1:0] sdat_q;
    logic [WORD_W-1:0] word_q;
    logic              hole_q;
    logic              tx_q;
    logic              seen_q;
    logic              under_q;

    logic [CNT_W-1:0]  wpos;
    logic [CNT_W-1:0]  spos;
    logic              new_bit;
    logic              held_bit;
    logic              sync_bit;

    // bit position within the word or sync field, same ordering rule for both
    assign wpos = msb_q ? (CNT_W'(wlen) - step) : step;
    assign spos = msb_q ? (CNT_W'(slen) - CNT_W'(1) - step) : step;

    assign new_bit  = |((wr_data >> wpos) & WORD_W'(1));
    assign held_bit = |((word_q  >> wpos) & WORD_W'(1));
    assign sync_bit = |((sdat_q  >> spos) & SYNC_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q   <= 1'b0;
            idle_q  <= 1'b0;
            sdat_q  <= '0;
            word_q  <= '0;
            hole_q  <= 1'b0;
            tx_q    <= 1'b0;
            seen_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            seen_q  <= accept;
            under_q <= slot_open && !wr_valid;
            if (accept) begin
                msb_q  <= cfg_msb_first;
                idle_q <= cfg_idle_lvl;
                sdat_q <= cfg_sync_data;
            end
            unique case (phase)
                PH_IDLE: tx_q <= cfg_idle_lvl;
                PH_SYNC: if (bit_en) tx_q <= sync_bit;
                PH_DATA: begin
                    if (slot_open) begin
                        if (wr_valid) begin
                            word_q <= wr_data;
                            hole_q <= 1'b0;
                            tx_q   <= new_bit;
                        end else begin
                            hole_q <= 1'b1;
                            tx_q   <= idle_q;
                        end
                    end else if (bit_en) begin
                        tx_q <= hole_q ? idle_q : held_bit;
                    end
                end
                default: if (bit_en) tx_q <= idle_q;
            endcase
        end
    end

    assign tx_data   = tx_q;
    assign sync_seen = seen_q;
    assign underrun  = under_q;

endmodule

// File: rtl/framed_sync_tx.sv
module framed_sync_tx
    import fstx_pkg::*;
#(
    parameter int  WORD_W    = 32,
    parameter int  SYNC_LO_W = 4,
    parameter int  DLY_W     = 8,
    parameter int  NWORD_W   = 8,
    localparam int LEN_W     = $clog2(WORD_W),
    localparam int SLEN_W    = SYNC_LO_W + 1,
    localparam int SYNC_W    = (1 << SLEN_W) - 1,
    localparam int CNT_W     = max3(LEN_W, SLEN_W, DLY_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               start_evt,
    input  logic               cfg_idle_lvl,
    input  logic               cfg_sync_en,
    input  logic               cfg_sync_len_hi,
    input  logic [SYNC_LO_W-1:0] cfg_sync_len_lo,
    input  logic [SYNC_W-1:0]  cfg_sync_data,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic [LEN_W-1:0]   cfg_word_len,
    input  logic               cfg_msb_first,
    input  logic [NWORD_W-1:0] cfg_word_cnt,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic               tx_data,
    output logic               tx_busy,
    output logic               sync_seen,
    output logic               underrun
);

    phase_t             phase;
    logic [CNT_W-1:0]   step;
    logic [LEN_W-1:0]   wlen;
    logic [SLEN_W-1:0]  slen;
    logic               accept;
    logic               slot_open;

    fstx_ctrl #(
        .LEN_W  (LEN_W),
        .SLEN_W (SLEN_W),
        .DLY_W  (DLY_W),
        .NWORD_W(NWORD_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .start_evt   (start_evt),
        .cfg_sync_en (cfg_sync_en),
        .cfg_sync_len({cfg_sync_len_hi, cfg_sync_len_lo}),
        .cfg_delay   (cfg_delay),
        .cfg_word_len(cfg_word_len),
        .cfg_word_cnt(cfg_word_cnt),
        .phase       (phase),
        .step        (step),
        .wlen        (wlen),
        .slen        (slen),
        .accept      (accept),
        .slot_open   (slot_open)
    );

    fstx_dpath #(
        .WORD_W(WORD_W),
        .SYNC_W(SYNC_W),
        .LEN_W (LEN_W),
        .SLEN_W(SLEN_W),
        .CNT_W (CNT_W)
    ) dpath_i (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .accept       (accept),
        .slot_open    (slot_open),
        .phase        (phase),
        .step         (step),
        .wlen         (wlen),
        .slen         (slen),
        .cfg_msb_first(cfg_msb_first),
        .cfg_idle_lvl (cfg_idle_lvl),
        .cfg_sync_data(cfg_sync_data),
        .wr_data      (wr_data),
        .wr_valid     (wr_valid),
        .tx_data      (tx_data),
        .sync_seen    (sync_seen),
        .underrun     (underrun)
    );

    assign tx_busy  = (phase != PH_IDLE);
    assign wr_ready = slot_open;

endmodule

// File: rtl/framed_sync_tx_chk.sv
module framed_sync_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic start_evt,
    input logic cfg_idle_lvl,
    input logic wr_valid,
    input logic wr_ready,
    input logic tx_data,
    input logic tx_busy,
    input logic sync_seen,
    input logic underrun
);

    AST_IDLE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && $past(!tx_busy) && $past(!rst)) |-> (tx_data == $past(cfg_idle_lvl))); // R1

    AST_START_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (start_evt && !tx_busy) |=> (sync_seen && tx_busy)); // R2

    AST_READY_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (bit_en && tx_busy)); // R6

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(!wr_valid && bit_en && tx_busy)); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_evt && tx_busy) |=> !sync_seen); // R8

    AST_END_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(bit_en)); // R9

    AST_HOLD_BETWEEN_BITS: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !bit_en) |=> $stable(tx_data)); // R10

endmodule

bind framed_sync_tx framed_sync_tx_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .start_evt   (start_evt),
    .cfg_idle_lvl(cfg_idle_lvl),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .tx_data     (tx_data),
    .tx_busy     (tx_busy),
    .sync_seen   (sync_seen),
    .underrun    (underrun)
);

// File: tb/framed_sync_tx_tb.sv
`timescale 1ns/1ps
module framed_sync_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        start_evt = 1'b0;
    logic        cfg_idle_lvl = 1'b0;
    logic        cfg_sync_en = 1'b0;
    logic        cfg_sync_len_hi = 1'b0;
    logic [3:0]  cfg_sync_len_lo = '0;
    logic [30:0] cfg_sync_data = '0;
    logic [7:0]  cfg_delay = '0;
    logic [4:0]  cfg_word_len = '0;
    logic        cfg_msb_first = 1'b0;
    logic [7:0]  cfg_word_cnt = '0;
    logic [31:0] wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready, tx_data, tx_busy, sync_seen, underrun;

    always #2.5 clk = ~clk;

    framed_sync_tx dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .start_evt(start_evt),
        .cfg_idle_lvl(cfg_idle_lvl), .cfg_sync_en(cfg_sync_en),
        .cfg_sync_len_hi(cfg_sync_len_hi), .cfg_sync_len_lo(cfg_sync_len_lo),
        .cfg_sync_data(cfg_sync_data), .cfg_delay(cfg_delay),
        .cfg_word_len(cfg_word_len), .cfg_msb_first(cfg_msb_first),
        .cfg_word_cnt(cfg_word_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .tx_data(tx_data), .tx_busy(tx_busy),
        .sync_seen(sync_seen), .underrun(underrun)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_test = "reset";

    // reference model state: one queue entry per remaining bit period
    int          ent_val[$];
    int          ent_step[$];
    string       ent_tag[$];
    logic [31:0] src_q[$];
    bit          feed_en = 1'b1;
    int          bit_div = 1;
    int          div_cnt = 0;
    logic [31:0] m_word;
    bit          m_hole, m_tx, m_sync, m_under, m_acc;
    string       m_tag = "R1";
    int          s_wlen, s_msb, s_idle;

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual=%0b expected=%0b at %0t", tag, cur_test, what, act, exp, $time);
        end
    endtask

    task automatic build_frame();
        int slen;
        slen   = {cfg_sync_len_hi, cfg_sync_len_lo};
        s_wlen = int'(cfg_word_len) + 1;
        s_msb  = cfg_msb_first;
        s_idle = cfg_idle_lvl;
        if (cfg_sync_en && slen > 0)
            for (int i = 0; i < slen; i++) begin
                ent_val.push_back(cfg_sync_data[s_msb ? slen - 1 - i : i]);
                ent_step.push_back(-1);
                ent_tag.push_back("R3");
            end
        for (int i = 0; i < int'(cfg_delay); i++) begin
            ent_val.push_back(s_idle); ent_step.push_back(-1); ent_tag.push_back("R4");
        end
        for (int w = 0; w <= int'(cfg_word_cnt); w++)
            for (int j = 0; j < s_wlen; j++) begin
                ent_val.push_back(0); ent_step.push_back(j); ent_tag.push_back("R5");
            end
        ent_val.push_back(s_idle); ent_step.push_back(-1); ent_tag.push_back("R9");
    endtask

    // model update on the clock edge, from inputs that are stable there
    always @(posedge clk) begin
        if (rst) begin
            ent_val.delete(); ent_step.delete(); ent_tag.delete();
            m_tx = 0; m_sync = 0; m_under = 0; m_tag = "R1";
        end else begin
            m_acc   = (ent_val.size() == 0) && start_evt;
            m_sync  = m_acc;
            m_under = 0;
            if (ent_val.size() == 0) begin
                m_tx  = cfg_idle_lvl;
                m_tag = "R1";
                if (m_acc) build_frame();
            end else if (bit_en) begin
                int v, st;
                string tg;
                v  = ent_val.pop_front();
                st = ent_step.pop_front();
                tg = ent_tag.pop_front();
                if (st < 0) begin
                    m_tx = v[0]; m_tag = tg;
                end else begin
                    if (st == 0) begin
                        if (wr_valid) begin
                            m_word = wr_data; m_hole = 0;
                            void'(src_q.pop_front());
                        end else begin
                            m_hole = 1; m_under = 1;
                        end
                    end
                    m_tx  = m_hole ? s_idle[0] : m_word[s_msb ? s_wlen - 1 - st : st];
                    m_tag = m_hole ? "R7" : "R5";
                end
            end
        end
    end

    // compare after the edge has settled
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            bit mbusy, mready;
            mbusy  = ent_val.size() != 0;
            mready = mbusy && bit_en && ent_step[0] == 0;
            chk(m_tag, tx_data, m_tx, "tx_data");
            chk("R9", tx_busy, mbusy, "tx_busy");
            chk("R6", wr_ready, mready, "wr_ready");
            chk("R2", sync_seen, m_sync, "sync_seen");
            chk("R7", underrun, m_under, "underrun");
        end
    end

    // input drivers away from the active edge
    always @(negedge clk) begin
        if (div_cnt >= bit_div - 1) begin
            bit_en <= 1'b1; div_cnt <= 0;
        end else begin
            bit_en <= 1'b0; div_cnt <= div_cnt + 1;
        end
        wr_valid <= feed_en && (src_q.size() > 0);
        wr_data  <= (src_q.size() > 0) ? src_q[0] : 32'h0;
    end

    task automatic do_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (ent_val.size() != 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_cfg(input bit sen, input bit hi, input int lo, input logic [30:0] sd,
                             input int dly, input int wl, input bit msb, input int wc, input bit idl);
        cfg_sync_en = sen; cfg_sync_len_hi = hi; cfg_sync_len_lo = 4'(lo);
        cfg_sync_data = sd; cfg_delay = 8'(dly); cfg_word_len = 5'(wl);
        cfg_msb_first = msb; cfg_word_cnt = 8'(wc); cfg_idle_lvl = idl;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: run did not end (actual cycles=150000 expected fewer)");
        finish_run();
    end

    initial begin
        cfg_idle_lvl = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs low during reset
        chk("R1", tx_data, 1'b0, "reset tx_data");
        chk("R1", tx_busy, 1'b0, "reset tx_busy");
        chk("R1", wr_ready, 1'b0, "reset wr_ready");
        chk("R1", sync_seen, 1'b0, "reset sync_seen");
        chk("R1", underrun, 1'b0, "reset underrun");
        rst = 1'b0;

        cur_test = "R1 idle level tracking";
        repeat (3) @(negedge clk);
        cfg_idle_lvl = 1'b0; repeat (3) @(negedge clk);
        cfg_idle_lvl = 1'b1; @(negedge clk);
        cfg_idle_lvl = 1'b0; repeat (2) @(negedge clk);

        cur_test = "R5 single byte MSB first";
        bit_div = 1;
        frame_cfg(0, 0, 0, 0, 0, 7, 1, 0, 0);
        src_q.push_back(32'h0000_00A5);
        do_start(); wait_done();

        cur_test = "R3 R4 R10 short sync, delay, LSB first, slow bits";
        bit_div = 3;
        frame_cfg(1, 0, 5, 31'h15, 3, 11, 0, 2, 1);
        src_q.push_back(32'h0000_0C35); src_q.push_back(32'h0000_0F0E); src_q.push_back(32'h0000_0801);
        do_start(); wait_done();

        cur_test = "R3 long sync via high length bit, full words MSB first";
        bit_div = 2;
        frame_cfg(1, 1, 3, 31'h5A3C_96E1, 0, 31, 1, 1, 0);
        src_q.push_back(32'hDEAD_BEEF); src_q.push_back(32'h8000_0001);
        do_start(); wait_done();

        cur_test = "R7 underrun on first slot";
        bit_div = 2; feed_en = 1'b0;
        frame_cfg(0, 0, 0, 0, 1, 3, 1, 2, 1);
        src_q.push_back(32'h0000_0009); src_q.push_back(32'h0000_0006);
        do_start();
        repeat (12) @(negedge clk);
        feed_en = 1'b1;
        wait_done();
        src_q.delete();

        cur_test = "R8 starts during busy frame";
        bit_div = 2;
        frame_cfg(1, 0, 4, 31'h9, 2, 5, 0, 1, 0);
        src_q.push_back(32'h0000_002B); src_q.push_back(32'h0000_0014);
        do_start();
        repeat (5) @(negedge clk); do_start();
        repeat (7) @(negedge clk); do_start();
        repeat (3) @(negedge clk); do_start();
        wait_done();

        cur_test = "R11 config changed mid-frame";
        bit_div = 1;
        frame_cfg(1, 0, 6, 31'h2D, 2, 9, 1, 1, 1);
        src_q.push_back(32'h0000_0355); src_q.push_back(32'h0000_00F3);
        do_start();
        frame_cfg(0, 1, 15, 31'h7FFF_FFFF, 9, 2, 0, 5, 0);
        wait_done();

        cur_test = "R4 maximum delay, one-bit word";
        bit_div = 1;
        frame_cfg(1, 0, 1, 31'h1, 255, 0, 0, 0, 0);
        src_q.push_back(32'h0000_0001);
        do_start(); wait_done();

        cur_test = "R3 sync enabled with zero length, back-to-back start";
        bit_div = 1;
        frame_cfg(1, 0, 0, 31'h7, 0, 3, 0, 0, 1);
        src_q.push_back(32'h0000_000A); src_q.push_back(32'h0000_0005);
        do_start();
        do @(negedge clk); while (ent_val.size() != 0);
        do_start(); wait_done();

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule